// File: doc/BRIEF.md
# Sequential Single-Precision Float Divider

This block divides two single-precision binary floating-point words over several clock cycles. A one-cycle `start` pulse presents dividend `a` and divisor `b`. The block works out the result sign and exponent with plain integer logic. It then restores the hidden leading one on both significands and runs a restoring shift-and-subtract loop that yields one quotient bit per clock. The truncated quotient is packed into `q` and flagged by a one-cycle `done` pulse.

The control is a three-state machine. **IDLE** waits for `start`. Transition *accept* loads the operands and enters **STEP**, where one quotient bit is formed per cycle. Transition *shortcut* goes from IDLE straight to **FINISH** when an operand is zero or the exponent underflows. Transition *last* leaves STEP for FINISH on the final quotient bit. Transition *release* returns from FINISH to IDLE after the single `done` cycle.

The handling of special values is kept minimal. Zero operands and exponent underflow both give an all-zero word. Rounding is truncation. Subnormal inputs, infinities, NaNs and exponent overflow are not handled.

Top module: `fdiv_seq`

## Requirements
- R1: If bits 30:0 of `a` or of `b` are all zero, the accepted operation returns `q` = 0x00000000 with no divide steps. A zero divisor never gives an infinity or NaN pattern.
- R2: Bit 31 of `q` is the XOR of bit 31 of `a` and bit 31 of `b`.
- R3: Let Ea and Eb be the exponent fields in bits 30:23, and let Ma and Mb be the fraction fields in bits 22:0 with a one placed at bit 23. The result exponent in `q[30:23]` is Ea − Eb + 127, minus one more when Ma < Mb.
- R4: `q[22:0]` is the low 23 bits of floor(Ma·2^23/Mb) when Ma ≥ Mb, and of floor(Ma·2^24/Mb) when Ma < Mb. The remainder is discarded, so the result is truncated toward zero.
- R5: `done` appears N+1 rising edges after the edge that samples `start`, counting that edge. N is 24 when Ma ≥ Mb, 25 when Ma < Mb, and 0 for the R1 and R6 shortcuts.
- R6: If the adjusted exponent from R3 is below zero, `q` is 0x00000000 and no divide steps run.
- R7: 0x43250000 divided by 0x40A00000 gives 0x42040000.
- R8: `start` is accepted only while `busy` is low. A `start` during STEP or FINISH changes neither the pending result nor its latency, and does not begin another operation.
- R9: `done` lasts exactly one cycle. `busy` is high from the cycle after acceptance through the `done` cycle. `q` holds its value until the next operation completes.
- R10: After synchronous reset, `busy`, `done` and `q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; sampled only while idle |
| a | input | 32 | Dividend word |
| b | input | 32 | Divisor word |
| busy | output | 1 | Operation in progress (STEP or FINISH) |
| done | output | 1 | One-cycle result-valid pulse |
| q | output | 32 | Quotient word |

## Verification
The in-design properties assume normal, non-subnormal operands. The hidden one must really lead the divisor significand, so that the partial remainder stays below twice the divisor and the final quotient bit lands at position 23. They also assume `start` is a clean synchronous level. The stimulus keeps every divisor exponent nonzero and draws both exponents from a middle band, so the adjusted exponent never passes 255. Underflow appears only through a small quotient exponent, and `start` is always driven on the falling edge.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_STEP   = 2'd1,
        S_FINISH = 2'd2
    } fdiv_state_e;
endpackage

// File: rtl/fdiv_unpack.sv
module fdiv_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int BIAS   = 127,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int EXPS_W = EXP_W + 2
) (
    input  logic [WORD_W-1:0]        a,
    input  logic [WORD_W-1:0]        b,
    output logic                     zero_op,
    output logic                     underflow,
    output logic                     sign,
    output logic                     long_run,
    output logic signed [EXPS_W-1:0] exp_adj,
    output logic [SIG_W-1:0]         sig_a,
    output logic [SIG_W-1:0]         sig_b
);
    logic signed [EXPS_W-1:0] ea_s, eb_s, bias_s;

    always_comb begin
        zero_op  = (a[WORD_W-2:0] == '0) || (b[WORD_W-2:0] == '0);
        sign     = a[WORD_W-1] ^ b[WORD_W-1];
        sig_a    = {1'b1, a[FRAC_W-1:0]};
        sig_b    = {1'b1, b[FRAC_W-1:0]};
        long_run = sig_a < sig_b;
        ea_s     = signed'({2'b00, a[WORD_W-2:FRAC_W]});
        eb_s     = signed'({2'b00, b[WORD_W-2:FRAC_W]});
        bias_s   = EXPS_W'(BIAS);
        exp_adj  = ea_s - (eb_s - bias_s) - (long_run ? EXPS_W'(1) : EXPS_W'(0));
        underflow = exp_adj[EXPS_W-1];
    end
endmodule

// File: rtl/fdiv_step.sv
module fdiv_step #(
    parameter int SIG_W = 24,
    localparam int REM_W = SIG_W + 1
) (
    input  logic [REM_W-1:0] rem_i,
    input  logic [SIG_W-1:0] div_i,
    input  logic [REM_W-1:0] quo_i,
    output logic [REM_W-1:0] rem_o,
    output logic [REM_W-1:0] quo_o
);
    logic             fits;
    logic [REM_W-1:0] kept;

    always_comb begin
        fits  = rem_i >= {1'b0, div_i};
        kept  = fits ? (rem_i - {1'b0, div_i}) : rem_i;
        rem_o = kept << 1;
        quo_o = {quo_i[REM_W-2:0], fits};
    end
endmodule

// File: rtl/fdiv_seq.sv
module fdiv_seq
    import fdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int BIAS   = 127,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int REM_W  = SIG_W + 1,
    localparam int EXPS_W = EXP_W + 2,
    localparam int CNT_W  = $clog2(SIG_W + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] q
);
    fdiv_state_e state_q, state_d;

    logic                     zero_op, underflow, sign_n, long_run;
    logic signed [EXPS_W-1:0] exp_adj;
    logic [SIG_W-1:0]         sig_a, sig_b;

    logic [REM_W-1:0]  rem_q, rem_n, quo_q, quo_n;
    logic [SIG_W-1:0]  div_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [EXP_W-1:0]  exp_q;
    logic              sign_q;
    logic [WORD_W-1:0] q_q;
    logic              last_step;

    fdiv_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) u_unpack (
        .a(a), .b(b), .zero_op(zero_op), .underflow(underflow),
        .sign(sign_n), .long_run(long_run), .exp_adj(exp_adj),
        .sig_a(sig_a), .sig_b(sig_b)
    );

    fdiv_step #(.SIG_W(SIG_W)) u_step (
        .rem_i(rem_q), .div_i(div_q), .quo_i(quo_q),
        .rem_o(rem_n), .quo_o(quo_n)
    );

    assign last_step = (state_q == S_STEP) && (cnt_q == CNT_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Transitions: accept, shortcut, last, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = (zero_op || underflow) ? S_FINISH : S_STEP;
            S_STEP:   if (last_step) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            div_q  <= '0;
            cnt_q  <= '0;
            exp_q  <= '0;
            sign_q <= 1'b0;
            q_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        if (zero_op || underflow) begin
                            q_q <= '0;
                        end else begin
                            rem_q  <= {1'b0, sig_a};
                            div_q  <= sig_b;
                            quo_q  <= '0;
                            cnt_q  <= long_run ? CNT_W'(SIG_W + 1) : CNT_W'(SIG_W);
                            exp_q  <= exp_adj[EXP_W-1:0];
                            sign_q <= sign_n;
                        end
                    end
                end
                S_STEP: begin
                    rem_q <= rem_n;
                    quo_q <= quo_n;
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (last_step)
                        q_q <= {sign_q, exp_q, quo_n[FRAC_W-1:0]};
                end
                S_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q == S_STEP) || (state_q == S_FINISH);
        done = (state_q == S_FINISH);
        q    = q_q;
    end

    p_zero_short_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && start && zero_op) |=> (done && q == '0));
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_STEP) |-> (rem_q < {div_q, 1'b0}));
    p_norm_r4: assert property (@(posedge clk) disable iff (rst)
        last_step |-> (quo_n[REM_W-1:REM_W-2] == 2'b01));
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE) |=> $stable(div_q));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/fdiv_seq_bench.sv
module fdiv_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic        busy, done;
    logic [31:0] q;
    int          checks = 0, fails = 0;
    logic [31:0] seed = 32'h1234_5677;

    always #5 clk = ~clk;

    fdiv_seq u_fdiv_seq (.clk(clk), .rst(rst), .start(start), .a(a), .b(b),
                         .busy(busy), .done(done), .q(q));

    function automatic logic [31:0] model_q(input logic [31:0] x, input logic [31:0] y);
        longint ma, mb, e, f;
        if (x[30:0] == 0 || y[30:0] == 0) return 32'h0;
        ma = longint'({1'b1, x[22:0]});
        mb = longint'({1'b1, y[22:0]});
        e  = longint'(x[30:23]) - longint'(y[30:23]) + 127;
        if (ma < mb) begin e = e - 1; f = (ma << 24) / mb; end
        else f = (ma << 23) / mb;
        if (e < 0) return 32'h0;
        return {x[31] ^ y[31], e[7:0], f[22:0]};
    endfunction

    function automatic int model_lat(input logic [31:0] x, input logic [31:0] y);
        longint e;
        if (x[30:0] == 0 || y[30:0] == 0) return 1;
        e = longint'(x[30:23]) - longint'(y[30:23]) + 127;
        if ({1'b1, x[22:0]} < {1'b1, y[22:0]}) e = e - 1;
        if (e < 0) return 1;
        return ({1'b1, x[22:0]} < {1'b1, y[22:0]}) ? 26 : 25;
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one operation; optional intrusive start while busy (R8)
    task automatic run_op(input string req, input logic [31:0] x, input logic [31:0] y,
                          input bit poke);
        int lat;
        @(negedge clk);
        a = x; b = y; start = 1'b1;
        @(posedge clk); lat = 1;
        @(negedge clk); start = 1'b0;
        while (!done && lat < 60) begin
            if (poke && lat == 4) begin
                chk("R9 busy during steps", {31'b0, busy}, 32'h1);
                a = ~x; b = y ^ 32'h0055_0000; start = 1'b1;
            end
            @(posedge clk); lat++;
            @(negedge clk); start = 1'b0;
        end
        chk({req, " result"}, q, model_q(x, y));
        chk("R5 latency", lat, model_lat(x, y));
        chk("R9 busy with done", {31'b0, busy}, 32'h1);
        if (poke) begin
            a = 32'h3F80_0000; b = 32'h3F80_0000; start = 1'b1;
            @(posedge clk);
            @(negedge clk); start = 1'b0;
            chk("R8 start in finish ignored", {30'b0, busy, done}, 32'h0);
            chk("R9 q held", q, model_q(x, y));
        end else begin
            @(posedge clk);
            @(negedge clk);
            chk("R9 done single pulse", {31'b0, done}, 32'h0);
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk("R10 reset outputs", {busy, done, q[29:0]}, 32'h0);
        chk("R10 reset q", q, 32'h0);

        run_op("R7 165/5", 32'h4325_0000, 32'h40A0_0000, 1'b0);
        chk("R7 literal", q, 32'h4204_0000);
        run_op("R2 negative dividend", 32'hC325_0000, 32'h40A0_0000, 1'b0);
        chk("R2 sign literal", q, 32'hC204_0000);
        run_op("R2 both negative", 32'hC325_0000, 32'hC0A0_0000, 1'b0);
        run_op("R3 long run 1/1.5", 32'h3F80_0000, 32'h3FC0_0000, 1'b0);
        chk("R4 truncated 2/3", q, 32'h3F2A_AAAA);
        run_op("R1 zero dividend", 32'h8000_0000, 32'h40A0_0000, 1'b0);
        run_op("R1 zero divisor", 32'h40A0_0000, 32'h0000_0000, 1'b0);
        chk("R1 no infinity", q, 32'h0);
        run_op("R6 underflow", 32'h0080_0000, 32'h7F00_0000, 1'b0);
        chk("R6 zero word", q, 32'h0);
        run_op("R8 start while busy", 32'h4325_0000, 32'h40A0_0000, 1'b1);
        run_op("R8 long run poke", 32'hBF80_0000, 32'h3FC0_0000, 1'b1);

        // Near-exhaustive sweep over top fraction bits (R3, R4, R2)
        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                run_op("R4 sweep",
                       {1'b0, 8'd130, ia[3:0], 19'h2A5A5},
                       {ib[0], 8'd125, ib[3:0], 19'h1C3C3}, 1'b0);
            end
        end

        // Scattered operands with exponents in a middle band (R3, R4, R6)
        for (int n = 0; n < 200; n++) begin
            logic [31:0] x, y;
            seed = nxt(seed); x = seed;
            seed = nxt(seed); y = seed;
            x[30:23] = 8'd64 + {1'b0, x[29:23]};
            y[30:23] = 8'd64 + {1'b0, y[29:23]};
            run_op("R3 scattered", x, y, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule